// File: doc/BRIEF.md
# Late-Capture Timing Error Monitor

The monitor watches a group of near-critical paths. Each path feeds two capture points. A main flop loads the path value when the normal capture enable is high. A shadow flop loads the same path value on a later sampling enable, which stands in for a delayed copy of the clock. When the two captures disagree on a path that is not excluded, that path reports an error. The block then raises one combined error, asks the pipeline to flush, and, once the flush interval ends, pulses a restore with the shadow value, which is taken to be correct.

The block also counts error events over a window whose length is set in cycles. At the end of each window it compares the event count with two thresholds. It recommends raising the supply when errors are too frequent and lowering it when they are rare. The supply controller can then step the voltage down until the error rate is just tolerable. While a flush is in progress, detection is suppressed, so one timing event is handled and counted only once.

Top module: `shadow_err_mon`

## Requirements
- R1: A main flop per path loads `data_i` on a clock edge with `cap_i`=1. A shadow flop loads it on an edge with `late_i`=1 when no flush is busy. On such a late edge, bit g of `err_vec_o` is 1 in the following cycle exactly when the new data bit differs from the stored main bit and `mask_i[g]`=0. A mask bit of 1 excludes the path.
- R2: `err_o` is 1 in a cycle exactly when any bit of `err_vec_o` is 1.
- R3: `flush_o` is a one-cycle pulse issued in the same cycle as `err_o`.
- R4: After a detection, `busy_o` is 1 for FLUSH_CYC cycles. Late edges seen while busy raise no error, update no shadow value and are not counted.
- R5: `restore_o` pulses for one cycle FLUSH_CYC cycles after `flush_o`. In that cycle `restore_data_o` holds the shadow value captured by the detecting edge, and `busy_o` is 0.
- R6: The window counts detection events, one per event, however many paths mismatch. The count saturates at its maximum.
- R7: A window ends every `win_len_i` cycles, starting from reset. In the cycle after the last edge of a window, `raise_o` pulses when count > `hi_thr_i`, or else `lower_o` pulses when count < `lo_thr_i`. Otherwise neither pulses.
- R8: When both threshold conditions hold, only `raise_o` pulses.
- R9: The event count restarts from zero for each window.
- R10: While `rst_ni` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | NPATH | Monitored path values |
| cap_i | input | 1 | Main capture enable |
| late_i | input | 1 | Delayed (shadow) capture enable |
| mask_i | input | NPATH | Per-path exclusion, 1 = ignore path |
| win_len_i | input | WIN_W | Window length in cycles (at least 1) |
| hi_thr_i | input | CNT_W | Raise threshold |
| lo_thr_i | input | CNT_W | Lower threshold |
| err_vec_o | output | NPATH | Per-path error bits |
| err_o | output | 1 | Combined error |
| flush_o | output | 1 | Flush request pulse |
| busy_o | output | 1 | Flush in progress, detection masked |
| restore_o | output | 1 | Restore pulse at end of flush |
| restore_data_o | output | NPATH | Shadow value to restore |
| raise_o | output | 1 | Raise-supply recommendation pulse |
| lower_o | output | 1 | Lower-supply recommendation pulse |

## Verification
The comparison is swept over every pairing of main and shadow values on a four-path configuration. The sweep runs under three masks: no mask, alternate paths masked and all paths masked. This separates a wrong XOR from a mask applied the wrong way round, or from the mask being ignored. Every detection is followed through its flush to check the restore pulse position and its data. A late mismatch driven inside the flush shows whether masking and shadow holding work. Whole windows are then run with zero to four spaced events, with back-to-back attempts, and with all paths mismatching at once. Thresholds are set so that a count off by one, an event counted per bit or twice, the priority when both conditions hold, and a count that carries into the next window each produce a different decision.

// File: rtl/shm_pkg.sv
package shm_pkg;

  typedef enum logic [1:0] {
    VOTE_HOLD  = 2'd0,
    VOTE_LOWER = 2'd1,
    VOTE_RAISE = 2'd2
  } vote_e;

  // raise has priority over lower
  function automatic vote_e pick_vote(input logic [31:0] cnt,
                                      input logic [31:0] hi,
                                      input logic [31:0] lo);
    if (cnt > hi)      return VOTE_RAISE;
    else if (cnt < lo) return VOTE_LOWER;
    else               return VOTE_HOLD;
  endfunction

endpackage

// File: rtl/shm_capture.sv
module shm_capture #(
  parameter int NPATH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPATH-1:0] data_i,
  input  logic             cap_i,
  input  logic             late_i,
  input  logic [NPATH-1:0] mask_i,
  input  logic             hold_i,
  output logic [NPATH-1:0] err_vec_o,
  output logic             err_any_o,
  output logic [NPATH-1:0] shadow_o,
  output logic             detect_o
);

  logic             late_ok;
  logic [NPATH-1:0] mism;
  logic             err_any_q;

  assign late_ok = late_i & ~hold_i;

  for (genvar g = 0; g < NPATH; g++) begin : g_path
    logic main_q;
    logic shad_q;
    logic ev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        main_q <= 1'b0;
        shad_q <= 1'b0;
        ev_q   <= 1'b0;
      end else begin
        if (cap_i)   main_q <= data_i[g];
        if (late_ok) shad_q <= data_i[g];
        ev_q <= mism[g];
      end
    end

    // compare against main value held before this edge
    assign mism[g]      = late_ok & ~mask_i[g] & (data_i[g] ^ main_q);
    assign err_vec_o[g] = ev_q;
    assign shadow_o[g]  = shad_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_any_q <= 1'b0;
    else         err_any_q <= |mism;
  end

  assign err_any_o = err_any_q;
  assign detect_o  = |mism;

endmodule

// File: rtl/shm_flush_ctl.sv
module shm_flush_ctl #(
  parameter int FLUSH_CYC = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic detect_i,
  output logic busy_o,
  output logic flush_o,
  output logic restore_o
);

  localparam int FC_W = $clog2(FLUSH_CYC + 1);
  localparam logic [FC_W-1:0] FC_LOAD = FC_W'(FLUSH_CYC);
  localparam logic [FC_W-1:0] FC_ONE  = FC_W'(1);

  logic [FC_W-1:0] cnt_q;
  logic            flush_q;
  logic            restore_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      flush_q   <= 1'b0;
      restore_q <= 1'b0;
    end else begin
      flush_q   <= detect_i;
      restore_q <= (cnt_q == FC_ONE) && !detect_i;
      if (detect_i)           cnt_q <= FC_LOAD;
      else if (cnt_q != '0)   cnt_q <= cnt_q - FC_ONE;
    end
  end

  assign busy_o    = (cnt_q != '0);
  assign flush_o   = flush_q;
  assign restore_o = restore_q;

endmodule

// File: rtl/shm_rate_ctl.sv
module shm_rate_ctl
  import shm_pkg::*;
#(
  parameter int WIN_W = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             event_i,
  input  logic [WIN_W-1:0] win_len_i,
  input  logic [CNT_W-1:0] hi_thr_i,
  input  logic [CNT_W-1:0] lo_thr_i,
  output logic             raise_o,
  output logic             lower_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [WIN_W:0]   WIN_ONE = (WIN_W+1)'(1);

  logic [WIN_W-1:0] wcnt_q;
  logic [WIN_W:0]   wcnt_inc;
  logic             win_end;
  logic [CNT_W-1:0] ecnt_q;
  logic [CNT_W-1:0] ecnt_nxt;
  vote_e            vote;
  logic             raise_q;
  logic             lower_q;

  assign wcnt_inc = {1'b0, wcnt_q} + WIN_ONE;
  assign win_end  = wcnt_inc >= {1'b0, win_len_i};
  assign ecnt_nxt = (event_i && ecnt_q != CNT_MAX) ? ecnt_q + CNT_ONE : ecnt_q;
  assign vote     = pick_vote(32'(ecnt_nxt), 32'(hi_thr_i), 32'(lo_thr_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcnt_q  <= '0;
      ecnt_q  <= '0;
      raise_q <= 1'b0;
      lower_q <= 1'b0;
    end else begin
      raise_q <= win_end && (vote == VOTE_RAISE);
      lower_q <= win_end && (vote == VOTE_LOWER);
      if (win_end) begin
        wcnt_q <= '0;
        ecnt_q <= '0;
      end else begin
        wcnt_q <= wcnt_inc[WIN_W-1:0];
        ecnt_q <= ecnt_nxt;
      end
    end
  end

  assign raise_o = raise_q;
  assign lower_o = lower_q;

endmodule

// File: rtl/shadow_err_mon.sv
module shadow_err_mon #(
  parameter int NPATH     = 8,
  parameter int FLUSH_CYC = 3,
  parameter int WIN_W     = 8,
  parameter int CNT_W     = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPATH-1:0] data_i,
  input  logic             cap_i,
  input  logic             late_i,
  input  logic [NPATH-1:0] mask_i,
  input  logic [WIN_W-1:0] win_len_i,
  input  logic [CNT_W-1:0] hi_thr_i,
  input  logic [CNT_W-1:0] lo_thr_i,
  output logic [NPATH-1:0] err_vec_o,
  output logic             err_o,
  output logic             flush_o,
  output logic             busy_o,
  output logic             restore_o,
  output logic [NPATH-1:0] restore_data_o,
  output logic             raise_o,
  output logic             lower_o
);

  logic detect;
  logic busy;

  shm_capture #(.NPATH(NPATH)) i_capture (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .data_i    (data_i),
    .cap_i     (cap_i),
    .late_i    (late_i),
    .mask_i    (mask_i),
    .hold_i    (busy),
    .err_vec_o (err_vec_o),
    .err_any_o (err_o),
    .shadow_o  (restore_data_o),
    .detect_o  (detect)
  );

  shm_flush_ctl #(.FLUSH_CYC(FLUSH_CYC)) i_flush (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .detect_i  (detect),
    .busy_o    (busy),
    .flush_o   (flush_o),
    .restore_o (restore_o)
  );

  shm_rate_ctl #(.WIN_W(WIN_W), .CNT_W(CNT_W)) i_rate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .event_i   (detect),
    .win_len_i (win_len_i),
    .hi_thr_i  (hi_thr_i),
    .lo_thr_i  (lo_thr_i),
    .raise_o   (raise_o),
    .lower_o   (lower_o)
  );

  assign busy_o = busy;

endmodule

// File: rtl/shm_chk.sv
module shm_chk #(
  parameter int NPATH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [NPATH-1:0] mask_i,
  input logic [NPATH-1:0] err_vec_o,
  input logic             err_o,
  input logic             flush_o,
  input logic             busy_o,
  input logic             restore_o,
  input logic             raise_o,
  input logic             lower_o
);

  // R1
  masked_path_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_vec_o & $past(mask_i)) == '0);

  // R2
  err_or_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o == (err_vec_o != '0));

  // R3
  flush_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o == err_o);

  // R3
  flush_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> !flush_o);

  // R4
  busy_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !err_o);

  // R4
  flush_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> busy_o);

  // R5
  restore_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_o |-> (!busy_o && $past(busy_o)));

  // R8
  vote_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({raise_o, lower_o}));

endmodule

bind shadow_err_mon shm_chk #(.NPATH(NPATH)) i_shm_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mask_i    (mask_i),
  .err_vec_o (err_vec_o),
  .err_o     (err_o),
  .flush_o   (flush_o),
  .busy_o    (busy_o),
  .restore_o (restore_o),
  .raise_o   (raise_o),
  .lower_o   (lower_o)
);

// File: tb/test_shadow_err_mon.sv
module test_shadow_err_mon;

  localparam int NP = 4;
  localparam int FC = 2;
  localparam int WW = 4;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NP-1:0] data;
  logic          cap;
  logic          late;
  logic [NP-1:0] mask;
  logic [WW-1:0] win_len;
  logic [CW-1:0] hi_thr;
  logic [CW-1:0] lo_thr;
  logic [NP-1:0] err_vec;
  logic          err;
  logic          flush;
  logic          busy;
  logic          restore;
  logic [NP-1:0] restore_data;
  logic          raise_v;
  logic          lower_v;

  int n_chk  = 0;
  int n_fail = 0;

  shadow_err_mon #(.NPATH(NP), .FLUSH_CYC(FC), .WIN_W(WW), .CNT_W(CW)) i_shadow_err_mon (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data), .cap_i(cap), .late_i(late),
    .mask_i(mask), .win_len_i(win_len), .hi_thr_i(hi_thr), .lo_thr_i(lo_thr),
    .err_vec_o(err_vec), .err_o(err), .flush_o(flush), .busy_o(busy),
    .restore_o(restore), .restore_data_o(restore_data),
    .raise_o(raise_v), .lower_o(lower_v)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cap = 1'b0; late = 1'b0; data = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // n events; spaced: edges 1,4,7,10 else consecutive edges 1..n
  task automatic win_run(input int n, input bit spaced, input logic [NP-1:0] ev_data,
                         input int hi, input int lo, input int exp_up, input int exp_dn,
                         input string req);
    mask = '0; win_len = WW'(12); hi_thr = CW'(hi); lo_thr = CW'(lo);
    do_reset();
    for (int k = 1; k <= 24; k++) begin
      bit ev;
      ev = spaced ? (((k - 1) % 3 == 0) && ((k - 1) / 3 < n) && k <= 12) : (k <= n);
      late = ev;
      data = ev ? ev_data : '0;
      @(negedge clk);
      if (k == 11) begin
        chk({req, " mid-window raise"}, int'(raise_v), 0);
        chk({req, " mid-window lower"}, int'(lower_v), 0);
      end
      if (k == 12) begin
        chk({req, " raise"}, int'(raise_v), exp_up);
        chk({req, " lower"}, int'(lower_v), exp_dn);
      end
      if (k == 24) begin
        // R9 second window has no events
        chk("R9 raise next window", int'(raise_v), 0);
        chk("R9 lower next window", int'(lower_v), (lo > 0) ? 1 : 0);
      end
    end
    late = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [NP-1:0] masks [3];
    masks[0] = 4'b0000; masks[1] = 4'b1010; masks[2] = 4'b1111;
    rst_n = 1'b0; cap = 1'b0; late = 1'b0; data = '0; mask = '0;
    win_len = WW'(15); hi_thr = CW'(15); lo_thr = CW'(0);
    repeat (3) @(negedge clk);
    // R10
    chk("R10 err_vec", int'(err_vec), 0);
    chk("R10 err", int'(err), 0);
    chk("R10 flush", int'(flush), 0);
    chk("R10 busy", int'(busy), 0);
    chk("R10 restore", int'(restore), 0);
    chk("R10 restore_data", int'(restore_data), 0);
    chk("R10 raise", int'(raise_v), 0);
    chk("R10 lower", int'(lower_v), 0);
    rst_n = 1'b1;

    // R1 R2 R3 R5: exhaustive main/shadow sweep under three masks
    for (int mi = 0; mi < 3; mi++) begin
      mask = masks[mi];
      for (int m = 0; m < 16; m++) begin
        for (int s = 0; s < 16; s++) begin
          int exp_v;
          @(negedge clk); cap = 1'b1; data = NP'(m);
          @(negedge clk); cap = 1'b0; late = 1'b1; data = NP'(s);
          @(negedge clk); late = 1'b0; data = '0;
          exp_v = (m ^ s) & ~int'(masks[mi]) & 15;
          chk("R1 err_vec", int'(err_vec), exp_v);
          chk("R2 err", int'(err), (exp_v != 0) ? 1 : 0);
          chk("R3 flush", int'(flush), (exp_v != 0) ? 1 : 0);
          if (exp_v != 0) begin
            chk("R4 busy after detect", int'(busy), 1);
            for (int j = 1; j <= FC; j++) begin
              @(negedge clk);
              if (j == 1) chk("R3 flush one cycle", int'(flush), 0);
              if (j < FC) chk("R5 restore early", int'(restore), 0);
              else begin
                chk("R5 restore pulse", int'(restore), 1);
                chk("R5 restore data", int'(restore_data), s);
                chk("R5 busy clear", int'(busy), 0);
              end
            end
            @(negedge clk);
            chk("R5 restore one cycle", int'(restore), 0);
          end
        end
      end
    end

    // R4: late mismatch inside flush is ignored and shadow holds
    mask = '0;
    @(negedge clk); cap = 1'b1; data = 4'h0;
    @(negedge clk); cap = 1'b0; late = 1'b1; data = 4'h5;
    @(negedge clk); data = 4'hA;
    chk("R4 detect before mask", int'(err), 1);
    @(negedge clk); late = 1'b0; data = '0;
    chk("R4 masked err", int'(err), 0);
    chk("R4 masked err_vec", int'(err_vec), 0);
    @(negedge clk);
    chk("R4 restore after masked edge", int'(restore), 1);
    chk("R4 shadow held", int'(restore_data), 5);
    @(negedge clk);

    // R7 R6 R8 R9: windowed rate decisions
    win_run(0, 1'b1, 4'h1, 2, 1, 0, 1, "R7 zero events");
    win_run(1, 1'b1, 4'h1, 2, 1, 0, 0, "R7 one event");
    win_run(2, 1'b1, 4'h1, 2, 1, 0, 0, "R7 count equal hi");
    win_run(3, 1'b1, 4'h1, 2, 1, 1, 0, "R7 count above hi");
    win_run(4, 1'b1, 4'h1, 2, 1, 1, 0, "R7 four events");
    win_run(1, 1'b1, 4'hF, 2, 1, 0, 0, "R6 all paths one event");
    win_run(3, 1'b0, 4'h1, 2, 2, 0, 1, "R4 back-to-back counted once");
    win_run(1, 1'b1, 4'h1, 0, 5, 1, 0, "R8 raise priority");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule